// File: doc/BRIEF.md
# Unordered Extended-Precision Float Comparator

This block takes a stack-top operand and a source operand, both in the 80-bit extended floating-point layout, and computes the four condition-code bits that a floating-point status word holds after an unordered compare. It also decodes the two opcode bytes of the compare instruction. From them it takes the number of stack pops the instruction needs, and it rejects opcodes that are not unordered compares. An operand that is a signaling NaN or an unsupported encoding raises an invalid-operation flag. In that case the codes are written only if the invalid mask input is set.

The operand layout is as follows. The sign is at bit 79. The biased exponent is at bits 78:64. The explicit integer bit is at bit 63 and the fraction is at bits 62:0. The result is registered: one clock after an accepted strobe, a one-cycle result-valid pulse appears together with the updated flags. The register stack, the status word storage and exception delivery stay with the surrounding pipeline.

Top module: `fcmp_unord`

## Requirements
- R1: For ordered operands, {C3,C2,C0} is 000 when the stack top is greater than the source, 001 when it is less, and 100 when the two are equal.
- R2: Zeros of either sign compare equal, so -0.0 against +0.0 gives 100.
- R3: A quiet NaN is an all-ones exponent with bits 63 and 62 set. If either operand is a quiet NaN and neither is a signaling NaN or unsupported, the result is 111 and invalid_o is 0.
- R4: A signaling NaN is an all-ones exponent with bit 63 set, bit 62 clear and a nonzero fraction. An unsupported value has a nonzero exponent and a clear bit 63. Either kind in either operand sets invalid_o. If inv_mask_i is 1, {C3,C2,C0} becomes 111.
- R5: If invalid is raised while inv_mask_i is 0, all four codes keep their previous values and cc_upd_o is 0. The pop count is still reported.
- R6: Whenever the codes are written, C1 is cleared.
- R7: pop_cnt_o is 0 for opcode bytes DD E0..E7, 1 for DD E8..EF, and 2 for DA E9.
- R8: A strobe with any other opcode produces no valid_o pulse and changes no output.
- R9: The outputs update one clock after an accepted valid_i. valid_o is high for exactly one cycle per accepted strobe.
- R10: Infinities and denormals are ordered by sign first. Within one sign they are ordered by magnitude, using exponent and significand together as one unsigned key.
- R11: While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Compare request strobe |
| st_top_i | input | 80 | Stack-top operand |
| src_i | input | 80 | Source operand |
| op0_i | input | 8 | First opcode byte |
| op1_i | input | 8 | Second opcode byte |
| inv_mask_i | input | 1 | Invalid-operation mask |
| valid_o | output | 1 | Result valid pulse |
| c3_o | output | 1 | Condition code C3 |
| c2_o | output | 1 | Condition code C2 |
| c1_o | output | 1 | Condition code C1 |
| c0_o | output | 1 | Condition code C0 |
| cc_upd_o | output | 1 | Codes were written by the last compare |
| invalid_o | output | 1 | Invalid operation raised by the last compare |
| pop_cnt_o | output | 2 | Stack pops required by the last compare |

## Verification
The bench builds the block with its default widths: a 15-bit exponent and a 64-bit significand that carries an explicit integer bit. Only this width brings the integer-bit encodings within reach. Unnormals, pseudo-infinities and pseudo-NaNs exist only where that bit is stored, so the unsupported-format path is exercised alongside the quiet and signaling NaNs, infinities and denormals.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO, CLS_FINITE, CLS_INF, CLS_QNAN, CLS_SNAN, CLS_BAD
  } fp_cls_e;

  typedef enum logic [1:0] {REL_GT, REL_LT, REL_EQ} rel_e;

  localparam logic [7:0] OPC_DD = 8'hDD;
  localparam logic [7:0] OPC_DA = 8'hDA;
  localparam logic [7:0] OPC_PP = 8'hE9;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] val_i,
  output fp_cls_e      cls_o
);
  logic [EXP_W-1:0] exp_w;
  logic [MAN_W-1:0] man_w;

  assign exp_w = val_i[W-2 -: EXP_W];
  assign man_w = val_i[MAN_W-1:0];

  always_comb begin
    if (&exp_w) begin
      if (!man_w[MAN_W-1])               cls_o = CLS_BAD;  // pseudo-inf / pseudo-NaN
      else if (man_w[MAN_W-2:0] == '0)   cls_o = CLS_INF;
      else if (man_w[MAN_W-2])           cls_o = CLS_QNAN;
      else                               cls_o = CLS_SNAN;
    end else if (exp_w != '0) begin
      cls_o = man_w[MAN_W-1] ? CLS_FINITE : CLS_BAD;     // unnormal
    end else begin
      cls_o = (man_w == '0) ? CLS_ZERO : CLS_FINITE;     // denormals ordered
    end
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int W = 80
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output rel_e         rel_o
);
  logic [W-2:0] key_a, key_b;
  logic         sa, sb, mag_gt;

  assign key_a  = a_i[W-2:0];
  assign key_b  = b_i[W-2:0];
  assign sa     = a_i[W-1];
  assign sb     = b_i[W-1];
  assign mag_gt = key_a > key_b;

  always_comb begin
    if (key_a == '0 && key_b == '0) rel_o = REL_EQ;
    else if (sa != sb)              rel_o = sa ? REL_LT : REL_GT;
    else if (key_a == key_b)        rel_o = REL_EQ;
    else                            rel_o = (mag_gt ^ sa) ? REL_GT : REL_LT;
  end
endmodule

// File: rtl/fcmp_decode.sv
module fcmp_decode
  import fcmp_pkg::*;
(
  input  logic [7:0] op0_i,
  input  logic [7:0] op1_i,
  output logic       accept_o,
  output logic [1:0] pop_o
);
  always_comb begin
    accept_o = 1'b0;
    pop_o    = 2'd0;
    if (op0_i == OPC_DD && op1_i[7:4] == 4'hE) begin
      accept_o = 1'b1;
      pop_o    = op1_i[3] ? 2'd1 : 2'd0;
    end else if (op0_i == OPC_DA && op1_i == OPC_PP) begin
      accept_o = 1'b1;
      pop_o    = 2'd2;
    end
  end
endmodule

// File: rtl/fcmp_unord.sv
module fcmp_unord
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] st_top_i,
  input  logic [W-1:0] src_i,
  input  logic [7:0]   op0_i,
  input  logic [7:0]   op1_i,
  input  logic         inv_mask_i,
  output logic         valid_o,
  output logic         c3_o,
  output logic         c2_o,
  output logic         c1_o,
  output logic         c0_o,
  output logic         cc_upd_o,
  output logic         invalid_o,
  output logic [1:0]   pop_cnt_o
);
  fp_cls_e    cls [2];
  logic [W-1:0] opnd [2];
  rel_e       rel;
  logic       accept, fire, any_q, any_bad, upd;
  logic [1:0] pop;
  logic [2:0] cc_nxt;

  assign opnd[0] = st_top_i;
  assign opnd[1] = src_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_cls (
      .val_i(opnd[g]),
      .cls_o(cls[g])
    );
  end

  fcmp_order #(.W(W)) i_order (
    .a_i  (st_top_i),
    .b_i  (src_i),
    .rel_o(rel)
  );

  fcmp_decode i_dec (
    .op0_i   (op0_i),
    .op1_i   (op1_i),
    .accept_o(accept),
    .pop_o   (pop)
  );

  assign any_q   = cls[0] == CLS_QNAN || cls[1] == CLS_QNAN;
  assign any_bad = cls[0] inside {CLS_SNAN, CLS_BAD} || cls[1] inside {CLS_SNAN, CLS_BAD};
  assign upd     = !any_bad || inv_mask_i;
  assign fire    = valid_i && accept;

  always_comb begin
    if (any_bad || any_q) cc_nxt = 3'b111;
    else begin
      case (rel)
        REL_GT:  cc_nxt = 3'b000;
        REL_LT:  cc_nxt = 3'b001;
        default: cc_nxt = 3'b100;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      c3_o      <= 1'b0;
      c2_o      <= 1'b0;
      c1_o      <= 1'b0;
      c0_o      <= 1'b0;
      cc_upd_o  <= 1'b0;
      invalid_o <= 1'b0;
      pop_cnt_o <= 2'd0;
    end else begin
      valid_o <= fire;
      if (fire) begin
        cc_upd_o  <= upd;
        invalid_o <= any_bad;
        pop_cnt_o <= pop;
        if (upd) begin
          {c3_o, c2_o, c0_o} <= cc_nxt;
          c1_o               <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fcmp_unord_chk.sv
module fcmp_unord_chk #(
  parameter int W = 80
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] st_top_i,
  input logic [W-1:0] src_i,
  input logic [7:0]   op0_i,
  input logic [7:0]   op1_i,
  input logic         inv_mask_i,
  input logic         valid_o,
  input logic         c3_o,
  input logic         c2_o,
  input logic         c1_o,
  input logic         c0_o,
  input logic         cc_upd_o,
  input logic         invalid_o,
  input logic [1:0]   pop_cnt_o
);
  logic req_ok;
  assign req_ok = valid_i && ((op0_i == 8'hDD && op1_i[7:4] == 4'hE) ||
                              (op0_i == 8'hDA && op1_i == 8'hE9));

  AST_ACCEPT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok |=> valid_o);  // R9
  AST_REJECT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ok |=> !valid_o && $stable({c3_o, c2_o, c1_o, c0_o, cc_upd_o, invalid_o, pop_cnt_o}));  // R8
  AST_C1_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && cc_upd_o |-> !c1_o);  // R6
  AST_UNMASKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !cc_upd_o |-> invalid_o && $stable({c3_o, c2_o, c1_o, c0_o}));  // R5
  AST_MASKED_UNORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && invalid_o && cc_upd_o |-> {c3_o, c2_o, c0_o} == 3'b111);  // R4
  AST_POP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> pop_cnt_o != 2'd3);  // R7
  AST_C2_IMPLIES_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && cc_upd_o && c2_o |-> c3_o && c0_o);  // R3
endmodule

bind fcmp_unord fcmp_unord_chk #(.W(W)) i_chk (.*);

// File: tb/test_fcmp_unord.sv
module test_fcmp_unord;
  localparam int W  = 80;
  localparam int NV = 15;

  localparam logic [W-1:0] P1   = 80'h3FFF_8000000000000000;
  localparam logic [W-1:0] P2   = 80'h4000_8000000000000000;
  localparam logic [W-1:0] N1   = 80'hBFFF_8000000000000000;
  localparam logic [W-1:0] N2   = 80'hC000_8000000000000000;
  localparam logic [W-1:0] PZ   = 80'h0000_0000000000000000;
  localparam logic [W-1:0] NZ   = 80'h8000_0000000000000000;
  localparam logic [W-1:0] PINF = 80'h7FFF_8000000000000000;
  localparam logic [W-1:0] NINF = 80'hFFFF_8000000000000000;
  localparam logic [W-1:0] QN   = 80'h7FFF_C000000000000000;
  localparam logic [W-1:0] SN   = 80'h7FFF_A000000000000000;
  localparam logic [W-1:0] UNN  = 80'h3FFF_4000000000000000;
  localparam logic [W-1:0] DEN  = 80'h0000_0000000000000001;
  localparam logic [W-1:0] PSI  = 80'h7FFF_0000000000000000;

  // {a, b, mask, cc3_2_0, invalid}
  localparam logic [2*W+4:0] VEC [NV] = '{
    {P2,   P1,  1'b0, 3'b000, 1'b0},  // R1 gt
    {P1,   P2,  1'b0, 3'b001, 1'b0},  // R1 lt
    {P1,   P1,  1'b0, 3'b100, 1'b0},  // R1 eq
    {N1,   P1,  1'b0, 3'b001, 1'b0},  // R1 sign
    {N1,   N2,  1'b0, 3'b000, 1'b0},  // R1 negatives
    {PZ,   NZ,  1'b0, 3'b100, 1'b0},  // R2
    {QN,   P1,  1'b0, 3'b111, 1'b0},  // R3
    {P1,   QN,  1'b0, 3'b111, 1'b0},  // R3
    {SN,   P1,  1'b1, 3'b111, 1'b1},  // R4 snan
    {UNN,  P1,  1'b1, 3'b111, 1'b1},  // R4 unnormal
    {PINF, P2,  1'b0, 3'b000, 1'b0},  // R10
    {DEN,  PZ,  1'b0, 3'b000, 1'b0},  // R10
    {NINF, DEN, 1'b0, 3'b001, 1'b0},  // R10
    {PSI,  PZ,  1'b1, 3'b111, 1'b1},  // R4 pseudo-inf
    {QN,   SN,  1'b1, 3'b111, 1'b1}   // R4 mixed
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] st_top_i = '0, src_i = '0;
  logic [7:0]   op0_i = 8'hDD, op1_i = 8'hE1;
  logic         inv_mask_i = 1'b0;
  logic         valid_o, c3_o, c2_o, c1_o, c0_o, cc_upd_o, invalid_o;
  logic [1:0]   pop_cnt_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  fcmp_unord i_fcmp_unord (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input logic [7:0] o0,
                     input logic [7:0] o1, input logic m);
    @(negedge clk_i);
    st_top_i = a; src_i = b; op0_i = o0; op1_i = o1; inv_mask_i = m; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R11 reset", {valid_o, c3_o, c2_o, c1_o, c0_o, cc_upd_o, invalid_o, 1'b0},
          8'h00);
    check("R11 pop", {6'd0, pop_cnt_o}, 8'h00);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][2*W+4 -: W], VEC[i][W+4 -: W], 8'hDD, 8'hE1, VEC[i][4]);
      check($sformatf("R1/R2/R3/R4/R10 vec%0d cc", i), {5'd0, c3_o, c2_o, c0_o},
            {5'd0, VEC[i][3:1]});
      check($sformatf("R4 vec%0d inv", i), {7'd0, invalid_o}, {7'd0, VEC[i][0]});
      check($sformatf("R6/R9 vec%0d", i), {5'd0, valid_o, cc_upd_o, c1_o}, 8'h06);
      check($sformatf("R7 vec%0d pop", i), {6'd0, pop_cnt_o}, 8'h00);
    end

    // R5: set codes to 001, then unmasked SNaN with single-pop opcode
    run(P1, P2, 8'hDD, 8'hE0, 1'b0);
    check("R1 pre", {5'd0, c3_o, c2_o, c0_o}, 8'h01);
    run(SN, P1, 8'hDD, 8'hEB, 1'b0);
    check("R5 codes held", {4'd0, c3_o, c2_o, c1_o, c0_o}, 8'h01);
    check("R5 flags", {5'd0, valid_o, cc_upd_o, invalid_o}, 8'h05);
    check("R5 R7 pop", {6'd0, pop_cnt_o}, 8'h01);

    // R7: double pop
    run(P2, P1, 8'hDA, 8'hE9, 1'b0);
    check("R7 pop2", {6'd0, pop_cnt_o}, 8'h02);
    check("R7 cc", {5'd0, c3_o, c2_o, c0_o}, 8'h00);

    // R8: rejected opcode changes nothing
    run(P1, P2, 8'hDA, 8'hE8, 1'b0);
    check("R8 no valid", {7'd0, valid_o}, 8'h00);
    check("R8 cc held", {5'd0, c3_o, c2_o, c0_o}, 8'h00);
    check("R8 pop held", {6'd0, pop_cnt_o}, 8'h02);
    run(P1, P2, 8'hD9, 8'hE0, 1'b0);
    check("R8 other byte", {7'd0, valid_o}, 8'h00);

    // R9: one-cycle pulse
    @(negedge clk_i);
    check("R9 pulse ends", {7'd0, valid_o}, 8'h00);

    // R11: reset mid-run clears outputs
    run(QN, P1, 8'hDD, 8'hEF, 1'b0);
    rst_ni = 1'b0;
    #1;
    check("R11 async clear", {c3_o, c2_o, c0_o, valid_o, pop_cnt_o, 2'b00}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule